// File: doc/BRIEF.md
# I2C Channel Readback Slave

This block is the serial-bus front end that lets a bus master read back one of several channel data words, together with the power-down mode, from a converter-style device. SCL and SDA are oversampled on a fast system clock through two-flop synchronizers. The block finds START, repeated START and STOP conditions from SDA edges while SCL is high, and it drives SDA only through an open-drain output enable. It never stretches the clock.

A transaction starts with a write to the device address followed by one control byte. That byte chooses the channel and whether a power-down byte comes before the data. After a repeated START and a read to the same address, the block captures the selected channel word and the power-down bits, and then shifts out two or three bytes, MSB first. A high-speed master code sent before the address is skipped without an acknowledge. An early NACK from the master silences the block until the next START.

Top module: `i2c_readback_slave`

## Requirements
- R1: A byte of the form 0000_1xxx received right after a START or repeated START is not acknowledged: SDA stays released in its ACK slot.
- R2: An address byte is matched as bits 7..3 = 10011, bits 2..1 equal to `addr_pin[1:0]`, bit 0 = R/W (0 write, 1 read). A match pulls SDA low in the ACK slot. Any other byte in that position gets no acknowledge.
- R3: After a matched write address, the next byte is acknowledged and latched as the control byte. Its bits 2..1 select the channel (0..3, word k at `chan_data[16k+15:16k]`) and its bit 0 sets the readback format. Bits 7..3 are ignored.
- R4: With control bit 0 = 0, a read returns two bytes: data bits 15..8, then bits 7..0.
- R5: With control bit 0 = 1, a read returns three bytes. The first is a power-down byte with `pd_mode[1:0]` in bits 7..6 and zeros below. The high data byte and then the low data byte follow.
- R6: When the master NACKs a byte, the block releases SDA and sends nothing more until the next START, so any further bytes clocked by the master read as 0xFF.
- R7: The channel word, power-down bits and format are captured when the read address is acknowledged. Input changes after that point do not alter the bytes of the same read, and they do show in the next read.
- R8: START and STOP return the byte framing to its initial state from any point, including mid-byte, so a complete transaction that follows one is served normally.
- R9: The block changes its SDA drive only while SCL is low, so SDA stays stable during every SCL high period of a transmitted bit.
- R10: During and after reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| addr_pin | input | 2 | Pin-strapped low address bits |
| chan_data | input | CHANNELS*DATA_W | Channel words, channel k in bits 16k+15..16k |
| pd_mode | input | PD_W | Power-down mode bits returned in the power-down byte |

## Verification
The hardest situation to reach is a change on the channel inputs that lands after the read address is acknowledged but before the data bits leave. Only a read that is stopped between its address ACK and its first data bit exposes the capture point. The bench splits the read into an address phase and a byte phase so that it can rewrite the selected channel word between them. A second read then shows the new word. The early-NACK case and the STOP or repeated START in the middle of an address byte are reached by bit-level bus tasks that can drop a byte part-way through.

// File: rtl/i2c_rb_pkg.sv
`timescale 1ns/1ps
package i2c_rb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_WAIT
   } rb_state_t;

   typedef enum logic [1:0] {
      NX_CTRL,
      NX_TX,
      NX_WAIT
   } rb_next_t;

   localparam int CTRL_SEL_LSB = 1;
   localparam int CTRL_FMT_BIT = 0;

endpackage

// File: rtl/i2c_rb_sync.sv
`timescale 1ns/1ps
module i2c_rb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '1;
         last  <= 1'b1;
      end else begin
         chain <= {chain[STAGES-2:0], line_i};
         last  <= chain[STAGES-1];
      end
   end

   assign line_s = chain[STAGES-1];
   assign rise   = line_s & ~last;
   assign fall   = ~line_s & last;
endmodule

// File: rtl/i2c_rb_cond.sv
`timescale 1ns/1ps
module i2c_rb_cond (
   input  logic scl_s,
   input  logic scl_rise,
   input  logic sda_rise,
   input  logic sda_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_steady_high;

   assign scl_steady_high = scl_s & ~scl_rise;
   assign start_det       = sda_fall & scl_steady_high;
   assign stop_det        = sda_rise & scl_steady_high;
endmodule

// File: rtl/i2c_rb_txmux.sv
`timescale 1ns/1ps
module i2c_rb_txmux #(
   parameter int DATA_W = 16,
   parameter int PD_W   = 2,
   parameter int IDX_W  = 2
) (
   input  logic [DATA_W-1:0] word_i,
   input  logic [PD_W-1:0]   pd_i,
   input  logic              with_pd_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [7:0]        byte_o
);
   localparam int NB_DATA = DATA_W / 8;

   logic [7:0]       data_bytes [NB_DATA];
   logic [7:0]       pd_byte;
   logic [IDX_W-1:0] didx;

   for (genvar j = 0; j < NB_DATA; j++) begin : g_bytes
      assign data_bytes[j] = word_i[DATA_W-1-8*j -: 8];
   end

   if (PD_W == 8) begin : g_pd_full
      assign pd_byte = pd_i;
   end else begin : g_pd_pad
      assign pd_byte = {pd_i, {(8-PD_W){1'b0}}};
   end

   assign didx = with_pd_i ? idx_i - 1'b1 : idx_i;

   always_comb begin
      byte_o = 8'hFF;
      if (with_pd_i && idx_i == '0) begin
         byte_o = pd_byte;
      end else begin
         for (int j = 0; j < NB_DATA; j++) begin
            if (didx == IDX_W'(j)) byte_o = data_bytes[j];
         end
      end
   end
endmodule

// File: rtl/i2c_readback_slave.sv
`timescale 1ns/1ps
module i2c_readback_slave
   import i2c_rb_pkg::*;
#(
   parameter int         CHANNELS    = 4,
   parameter int         DATA_W      = 16,
   parameter int         PD_W        = 2,
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] DEV_ID      = 5'b10011
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   input  logic [1:0]                 addr_pin,
   input  logic [CHANNELS*DATA_W-1:0] chan_data,
   input  logic [PD_W-1:0]            pd_mode
);
   localparam int NB_DATA = DATA_W / 8;
   localparam int NB_MAX  = NB_DATA + 1;
   localparam int IDX_W   = $clog2(NB_MAX + 1);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 8");
   end
   if (PD_W < 1 || PD_W > 8) begin : g_bad_pd
      $error("PD_W must lie in 1..8");
   end
   if (CHANNELS < 2 || CHANNELS > 4) begin : g_bad_chan
      $error("CHANNELS must lie in 2..4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;
   logic start_det, stop_det;

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .line_s(scl_s), .rise(scl_rise), .fall(scl_fall)
   );

   i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .line_s(sda_s), .rise(sda_rise), .fall(sda_fall)
   );

   i2c_rb_cond u_cond (
      .scl_s(scl_s), .scl_rise(scl_rise),
      .sda_rise(sda_rise), .sda_fall(sda_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   rb_state_t         state;
   rb_next_t          nxt;
   logic [7:0]        shreg;
   logic [2:0]        bitcnt;
   logic              byte_full;
   logic              rx_addr;
   logic              more;
   logic [IDX_W-1:0]  idx;
   logic [1:0]        sel_q;
   logic              fmt_q;
   logic [DATA_W-1:0] snap_word;
   logic [PD_W-1:0]   snap_pd;
   logic              snap_fmt;

   logic [DATA_W-1:0] ch_words [CHANNELS];
   logic [DATA_W-1:0] sel_word;
   logic              addr_hit;
   logic [IDX_W-1:0]  last_idx;
   logic [IDX_W-1:0]  tx_idx;
   logic [7:0]        tx_byte;

   for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
      assign ch_words[k] = chan_data[k*DATA_W +: DATA_W];
   end

   always_comb begin
      sel_word = '0;
      for (int k = 0; k < CHANNELS; k++) begin
         if (sel_q == 2'(k)) sel_word = ch_words[k];
      end
   end

   assign addr_hit = (shreg[7:3] == DEV_ID) && (shreg[2:1] == addr_pin);
   assign last_idx = snap_fmt ? IDX_W'(NB_DATA) : IDX_W'(NB_DATA - 1);
   assign tx_idx   = (state == ST_ACK) ? '0 : idx + 1'b1;

   i2c_rb_txmux #(.DATA_W(DATA_W), .PD_W(PD_W), .IDX_W(IDX_W)) u_txmux (
      .word_i(snap_word), .pd_i(snap_pd), .with_pd_i(snap_fmt),
      .idx_i(tx_idx), .byte_o(tx_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         nxt       <= NX_WAIT;
         shreg     <= '0;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         rx_addr   <= 1'b1;
         more      <= 1'b0;
         idx       <= '0;
         sel_q     <= '0;
         fmt_q     <= 1'b0;
         snap_word <= '0;
         snap_pd   <= '0;
         snap_fmt  <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (start_det) begin
         state     <= ST_RX;
         nxt       <= NX_WAIT;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         rx_addr   <= 1'b1;
         more      <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         byte_full <= 1'b0;
         more      <= 1'b0;
         sda_oe    <= 1'b0;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == 3'd7) byte_full <= 1'b1;
               end else if (scl_fall && byte_full) begin
                  byte_full <= 1'b0;
                  if (rx_addr) begin
                     if (addr_hit) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK;
                        if (shreg[0]) begin
                           nxt       <= NX_TX;
                           idx       <= '0;
                           snap_word <= sel_word;
                           snap_pd   <= pd_mode;
                           snap_fmt  <= fmt_q;
                        end else begin
                           nxt <= NX_CTRL;
                        end
                     end else begin
                        state <= ST_WAIT;
                     end
                  end else begin
                     sel_q  <= shreg[CTRL_SEL_LSB +: 2];
                     fmt_q  <= shreg[CTRL_FMT_BIT];
                     sda_oe <= 1'b1;
                     nxt    <= NX_WAIT;
                     state  <= ST_ACK;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  case (nxt)
                     NX_TX: begin
                        shreg  <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        state  <= ST_TX;
                     end
                     NX_CTRL: begin
                        sda_oe  <= 1'b0;
                        rx_addr <= 1'b0;
                        state   <= ST_RX;
                     end
                     default: begin
                        sda_oe <= 1'b0;
                        state  <= ST_WAIT;
                     end
                  endcase
               end
            end
            ST_TX: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == 3'd7) byte_full <= 1'b1;
               end else if (scl_fall) begin
                  if (byte_full) begin
                     byte_full <= 1'b0;
                     sda_oe    <= 1'b0;
                     state     <= ST_MACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     sda_oe <= ~shreg[6];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  if (!sda_s && idx != last_idx) more  <= 1'b1;
                  else                           state <= ST_WAIT;
               end else if (scl_fall && more) begin
                  more   <= 1'b0;
                  idx    <= idx + 1'b1;
                  shreg  <= tx_byte;
                  sda_oe <= ~tx_byte[7];
                  bitcnt <= '0;
                  state  <= ST_TX;
               end
            end
            default: begin
               sda_oe <= 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/i2c_rb_checker.sv
`timescale 1ns/1ps
module i2c_rb_checker
   import i2c_rb_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              start_det,
   input logic              stop_det,
   input logic              sda_oe,
   input rb_state_t         state,
   input logic [IDX_W-1:0]  idx,
   input logic [IDX_W-1:0]  last_idx,
   input logic [DATA_W-1:0] snap_word
);
   assert_drive_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   assert_release_on_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_oe);

   assert_silent_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT || state == ST_IDLE) |-> !sda_oe);

   assert_index_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX || state == ST_MACK) |-> (idx <= last_idx));

   assert_snapshot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX) |-> $stable(snap_word));
endmodule

bind i2c_readback_slave i2c_rb_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .state(state), .idx(idx),
   .last_idx(last_idx), .snap_word(snap_word)
);

// File: tb/i2c_readback_slave_test.sv
`timescale 1ns/1ps
module i2c_readback_slave_test;
   localparam int Q = 100;
   localparam logic [7:0] WR_ADDR = 8'h9A;
   localparam logic [7:0] RD_ADDR = 8'h9B;
   // {control byte, expected bytes}; two-byte reads use the low 16 bits
   localparam logic [31:0] VEC [5] = '{
      32'h00_00A51C, 32'h03_803E07, 32'h04_00F0F1, 32'hCF_800080, 32'h35_80F0F1
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic        sda_i;
   logic [1:0]  addr_pin = 2'b01;
   logic [63:0] chan_data = {16'h0080, 16'hF0F1, 16'h3E07, 16'hA51C};
   logic [1:0]  pd_mode = 2'b10;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;
   assign sda_i = sda_m & ~sda_oe;

   i2c_readback_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_i), .sda_oe(sda_oe),
      .addr_pin(addr_pin), .chan_data(chan_data), .pd_mode(pd_mode)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
   endtask

   task automatic send_bits(input logic [7:0] b, input int nb);
      for (int i = 7; i > 7 - nb; i--) begin
         sda_m = b[i]; #Q; scl_m = 1'b1; #Q; #Q; scl_m = 1'b0; #Q;
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      sda_m = 1'b1; #Q; scl_m = 1'b1; #Q;
      ack = (sda_i == 1'b0);
      #Q; scl_m = 1'b0; #Q;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit steady);
      logic first;
      steady = 1'b1;
      b = '0;
      sda_m = 1'b1;
      for (int i = 0; i < 8; i++) begin
         #Q; scl_m = 1'b1; #Q;
         first = sda_i;
         b = {b[6:0], first};
         #Q;
         if (sda_i !== first) steady = 1'b0;
         scl_m = 1'b0; #Q;
      end
      sda_m = give_ack ? 1'b0 : 1'b1;
      #Q; scl_m = 1'b1; #Q; #Q; scl_m = 1'b0; #Q;
      sda_m = 1'b1;
   endtask

   task automatic write_ctrl(input logic [7:0] ctrl, input bit hs);
      bit ack;
      bus_start();
      if (hs) begin
         send_byte(8'h08, ack);
         chk("R1 master code", 32'(ack), 32'd0);
         bus_start();
      end
      send_byte(WR_ADDR, ack);
      chk("R2 write address", 32'(ack), 32'd1);
      send_byte(ctrl, ack);
      chk("R3 control byte", 32'(ack), 32'd1);
   endtask

   task automatic read_bytes(input int n, output logic [23:0] got);
      logic [7:0] b;
      bit         st;
      got = '0;
      for (int k = 0; k < n; k++) begin
         recv_byte(k != n - 1, b, st);
         got = {got[15:0], b};
         chk("R9 stable SDA", 32'(st), 32'd1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      bit          ack;
      logic [23:0] got;
      logic [7:0]  b;
      bit          st;

      repeat (8) @(posedge clk);
      chk("R10 reset drive", 32'(sda_oe), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R10 after reset", 32'(sda_oe), 32'd0);

      // vector table: master code, write, control, read
      for (int v = 0; v < 5; v++) begin
         logic [7:0]  ctrl;
         logic [23:0] exp;
         int          n;
         ctrl = VEC[v][31:24];
         exp  = VEC[v][23:0];
         n    = ctrl[0] ? 3 : 2;
         write_ctrl(ctrl, 1'b1);
         bus_start();
         send_byte(RD_ADDR, ack);
         chk("R2 read address", 32'(ack), 32'd1);
         read_bytes(n, got);
         bus_stop();
         if (n == 3) chk("R5 R3 three-byte read", 32'(got), 32'(exp));
         else        chk("R4 R3 two-byte read", 32'(got[15:0]), 32'(exp[15:0]));
      end

      // R2: wrong strap bits and wrong fixed bits
      bus_start();
      send_byte(8'h9C, ack);
      chk("R2 strap mismatch", 32'(ack), 32'd0);
      bus_start();
      send_byte(8'h1A, ack);
      chk("R2 fixed bits mismatch", 32'(ack), 32'd0);
      bus_stop();

      // R6: early NACK after power-down byte
      write_ctrl(8'h01, 1'b0);
      bus_start();
      send_byte(RD_ADDR, ack);
      chk("R2 read address", 32'(ack), 32'd1);
      recv_byte(1'b0, b, st);
      chk("R5 power-down byte", 32'(b), 32'h80);
      recv_byte(1'b0, b, st);
      chk("R6 after early NACK", 32'(b), 32'hFF);
      bus_stop();

      // R7: change the selected word after the read address ACK
      write_ctrl(8'h02, 1'b0);
      bus_start();
      send_byte(RD_ADDR, ack);
      chan_data[31:16] = 16'h1234;
      read_bytes(2, got);
      bus_stop();
      chk("R7 captured word", 32'(got[15:0]), 32'h3E07);
      bus_start();
      send_byte(RD_ADDR, ack);
      read_bytes(2, got);
      bus_stop();
      chk("R7 next read sees update", 32'(got[15:0]), 32'h1234);
      chan_data[31:16] = 16'h3E07;

      // R8: STOP mid-byte, then repeated START mid-byte
      bus_start();
      send_bits(WR_ADDR, 4);
      bus_stop();
      chk("R8 released after STOP", 32'(sda_oe), 32'd0);
      bus_start();
      send_bits(RD_ADDR, 3);
      bus_start();
      send_byte(WR_ADDR, ack);
      chk("R8 address after restart", 32'(ack), 32'd1);
      send_byte(8'h00, ack);
      chk("R8 control after restart", 32'(ack), 32'd1);
      bus_start();
      send_byte(RD_ADDR, ack);
      read_bytes(2, got);
      bus_stop();
      chk("R8 read after aborted bytes", 32'(got[15:0]), 32'hA51C);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule